// File: doc/BRIEF.md
# Branch prediction result expander

This block turns a compact fetch-target-buffer record into the full form of a prediction result that later predictor stages consume. It takes the stored record, a flag saying whether the lookup hit, and the start address of the current fetch block. From these it rebuilds each slot's full target address and the block's complete fall-through address. It also derives the jump-type flags and the taken mask, and marks a fall-through address that cannot be correct.

The record has two slots. The first holds a conditional branch with 12 stored low target bits. The second is the tail slot. It holds either an unconditional jump with 20 stored low bits, or, when marked shared, a second conditional branch with 12 low bits. A target is rebuilt from the upper bits of the start address, moved up or down by one according to a 2-bit status, with the stored low bits appended. The result is registered once, and an output valid follows the input valid by one cycle.

Top module: `bpx_expander`

## Requirements
- R1: The branch-slot target is `{A, lower[11:0]}`, where A is `pc[38:12]` adjusted by the status: 0 unchanged, 1 plus one, 2 minus one, 3 unchanged. The adjustment wraps modulo the width of A.
- R2: The tail-slot target uses the same rule with 20 low bits (A = `pc[38:20]`) when not shared, and with 12 low bits when shared. The jalr target output always equals the tail-slot target.
- R3: On a hit, the raw fall-through is `{pc[38:5] + carry, part[3:0], 1'b0}`.
- R4: On a hit, the error flag is raised when the raw fall-through is not greater than pc, or when it is greater than pc+32. The fall-through output is then pc+32. A raw value equal to pc+32 is not an error.
- R5: On a hit, is_jalr, is_call and is_ret copy the stored type bits only when the tail slot is valid and not shared. is_jal is set under the same condition when the jalr bit is clear. The shared output is set when the tail slot is valid and shared.
- R6: taken[0] is set when the branch slot is valid and always_taken[0] is set. taken[1] is set when the tail slot is valid, shared and always_taken[1] is set.
- R7: The slot valid bits (bit 0 branch, bit 1 tail) and both offsets are copied from the record. On a miss, both valid bits are low.
- R8: On a miss, the fall-through output is pc+32, the error flag is low, and all type flags and the taken mask are zero.
- R9: The outputs change only on the clock edge where the input valid is high. The output valid equals the input valid delayed by one cycle.
- R10: After reset, the output valid and all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input record is present this cycle |
| in_hit | input | 1 | Lookup hit |
| in_pc | input | VA_W | Start address of the fetch block |
| rec_br_valid | input | 1 | Branch slot occupied |
| rec_br_offset | input | OFF_W | Branch slot position in the block |
| rec_br_lower | input | BR_LOW_W | Branch slot stored low target bits |
| rec_br_stat | input | 2 | Branch slot upper-bit adjustment |
| rec_tail_valid | input | 1 | Tail slot occupied |
| rec_tail_offset | input | OFF_W | Tail slot position in the block |
| rec_tail_lower | input | JMP_LOW_W | Tail slot stored low target bits |
| rec_tail_stat | input | 2 | Tail slot upper-bit adjustment |
| rec_tail_shared | input | 1 | Tail slot holds a conditional branch |
| rec_fall_part | input | OFF_W | Partial fall-through position |
| rec_fall_carry | input | 1 | Carry into the block-aligned upper bits |
| rec_is_call | input | 1 | Tail jump is a call |
| rec_is_ret | input | 1 | Tail jump is a return |
| rec_is_jalr | input | 1 | Tail jump is register-indirect |
| rec_always_taken | input | 2 | Per-slot always-taken bits |
| out_valid | output | 1 | Result present |
| out_slot_valid | output | 2 | Per-slot valid |
| out_br_target | output | VA_W | Branch slot target |
| out_tail_target | output | VA_W | Tail slot target |
| out_br_offset | output | OFF_W | Branch slot offset |
| out_tail_offset | output | OFF_W | Tail slot offset |
| out_fall_addr | output | VA_W | Fall-through address |
| out_fall_err | output | 1 | Stored fall-through rejected |
| out_is_jal | output | 1 | Direct jump in tail |
| out_is_jalr | output | 1 | Indirect jump in tail |
| out_is_call | output | 1 | Call in tail |
| out_is_ret | output | 1 | Return in tail |
| out_shared | output | 1 | Tail slot holds a conditional branch |
| out_taken | output | 2 | Taken mask |
| out_jalr_target | output | VA_W | Indirect jump target |

## Verification
The assertions assume that the input valid is low while reset is asserted. They also assume that the miss-path address pc+32 is computed modulo the address width. The bench keeps the input valid low through reset. It draws start addresses over the whole 39-bit range, so the wrap cases of the adjusted upper bits and of the fall-through carry are reached. Directed vectors cover status 3, a shared tail, a miss, and both error bounds, including a raw fall-through exactly at pc+32.

// File: rtl/bpx_pkg.sv
// Shared definitions for the prediction result expander.
// Assumes a two-slot record: slot 0 conditional, slot 1 tail.
package bpx_pkg;
    localparam int NUM_SLOTS = 2;

    typedef enum logic [1:0] {
        TS_KEEP = 2'd0,
        TS_INC  = 2'd1,
        TS_DEC  = 2'd2,
        TS_RSVD = 2'd3
    } tstat_e;
endpackage

// File: rtl/bpx_rebuild.sv
// Rebuilds a full target from the upper start-address bits and stored low bits.
// Assumes the stat code follows bpx_pkg::tstat_e, with the reserved code read as keep.
module bpx_rebuild #(
    parameter int VA_W  = 39,
    parameter int LOW_W = 12
) (
    input  logic [VA_W-LOW_W-1:0] pc_hi,
    input  logic [LOW_W-1:0]      lower,
    input  logic [1:0]            stat,
    output logic [VA_W-1:0]       target
);
    import bpx_pkg::*;

    logic [VA_W-LOW_W-1:0] hi_adj;

    // Move the upper bits by the encoded step and append the low bits.
    always_comb begin
        unique case (tstat_e'(stat))
            TS_INC:  hi_adj = pc_hi + 1'b1;
            TS_DEC:  hi_adj = pc_hi - 1'b1;
            default: hi_adj = pc_hi;
        endcase
        target = {hi_adj, lower};
    end
endmodule

// File: rtl/bpx_fall_gen.sv
// Rebuilds the fall-through address from a partial position plus a carry and checks it.
// Assumes the block spans PRED_W instructions of 2**ALN_W bytes each.
module bpx_fall_gen #(
    parameter int VA_W   = 39,
    parameter int PRED_W = 16,
    parameter int ALN_W  = 1
) (
    input  logic                      hit,
    input  logic [VA_W-1:0]           pc,
    input  logic [$clog2(PRED_W)-1:0] part,
    input  logic                      carry,
    output logic [VA_W-1:0]           fall_addr,
    output logic                      fall_err
);
    localparam int OFF_W  = $clog2(PRED_W);
    localparam int HI_LSB = OFF_W + ALN_W;
    localparam logic [VA_W-1:0] SPAN = VA_W'(PRED_W * (1 << ALN_W));

    logic [VA_W-HI_LSB-1:0] hi_sum;
    logic [VA_W-1:0]        raw;
    logic [VA_W-1:0]        limit;

    // Join the carried upper bits with the partial position and the zero alignment bits.
    always_comb begin
        hi_sum = pc[VA_W-1:HI_LSB] + {{(VA_W-HI_LSB-1){1'b0}}, carry};
        raw    = {hi_sum, part, {ALN_W{1'b0}}};
        limit  = pc + SPAN;
    end

    // Reject values outside (pc, pc+SPAN] and fall back to the full block length.
    always_comb begin
        fall_err  = hit && ((raw <= pc) || (raw > limit));
        fall_addr = (hit && !fall_err) ? raw : limit;
    end
endmodule

// File: rtl/bpx_flag_gen.sv
// Derives slot valids, jump-type flags, the sharing flag and the taken mask.
// Assumes slot 0 is the conditional slot and slot 1 the tail slot.
module bpx_flag_gen (
    input  logic       hit,
    input  logic       br_valid,
    input  logic       tail_valid,
    input  logic       tail_shared,
    input  logic       is_call,
    input  logic       is_ret,
    input  logic       is_jalr,
    input  logic [1:0] always_taken,
    output logic [1:0] slot_valid,
    output logic [1:0] taken,
    output logic       jal_o,
    output logic       jalr_o,
    output logic       call_o,
    output logic       ret_o,
    output logic       shared_o
);
    logic tail_jump;

    // Gate the slot valids by hit and classify the tail slot.
    always_comb begin
        slot_valid = {hit & tail_valid, hit & br_valid};
        tail_jump  = slot_valid[1] & ~tail_shared;
        shared_o   = slot_valid[1] & tail_shared;
        jalr_o     = tail_jump & is_jalr;
        jal_o      = tail_jump & ~is_jalr;
        call_o     = tail_jump & is_call;
        ret_o      = tail_jump & is_ret;
    end

    // A slot contributes to the taken mask only while it holds a conditional branch.
    always_comb begin
        taken[0] = slot_valid[0] & always_taken[0];
        taken[1] = shared_o & always_taken[1];
    end
endmodule

// File: rtl/bpx_expander.sv
// Expands a stored two-slot record into a registered full prediction result.
// Assumes inputs are stable for the cycle in_valid is high; outputs hold otherwise.
module bpx_expander #(
    parameter int VA_W      = 39,
    parameter int PRED_W    = 16,
    parameter int ALN_W     = 1,
    parameter int BR_LOW_W  = 12,
    parameter int JMP_LOW_W = 20,
    localparam int OFF_W    = $clog2(PRED_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_hit,
    input  logic [VA_W-1:0]      in_pc,
    input  logic                 rec_br_valid,
    input  logic [OFF_W-1:0]     rec_br_offset,
    input  logic [BR_LOW_W-1:0]  rec_br_lower,
    input  logic [1:0]           rec_br_stat,
    input  logic                 rec_tail_valid,
    input  logic [OFF_W-1:0]     rec_tail_offset,
    input  logic [JMP_LOW_W-1:0] rec_tail_lower,
    input  logic [1:0]           rec_tail_stat,
    input  logic                 rec_tail_shared,
    input  logic [OFF_W-1:0]     rec_fall_part,
    input  logic                 rec_fall_carry,
    input  logic                 rec_is_call,
    input  logic                 rec_is_ret,
    input  logic                 rec_is_jalr,
    input  logic [1:0]           rec_always_taken,
    output logic                 out_valid,
    output logic [1:0]           out_slot_valid,
    output logic [VA_W-1:0]      out_br_target,
    output logic [VA_W-1:0]      out_tail_target,
    output logic [OFF_W-1:0]     out_br_offset,
    output logic [OFF_W-1:0]     out_tail_offset,
    output logic [VA_W-1:0]      out_fall_addr,
    output logic                 out_fall_err,
    output logic                 out_is_jal,
    output logic                 out_is_jalr,
    output logic                 out_is_call,
    output logic                 out_is_ret,
    output logic                 out_shared,
    output logic [1:0]           out_taken,
    output logic [VA_W-1:0]      out_jalr_target
);
    logic [VA_W-1:0] br_tgt, tail_wide_tgt, tail_narrow_tgt, tail_tgt;
    logic [VA_W-1:0] fall_addr;
    logic            fall_err;
    logic [1:0]      slot_valid, taken;
    logic            f_jal, f_jalr, f_call, f_ret, f_shared;

    bpx_rebuild #(.VA_W(VA_W), .LOW_W(BR_LOW_W)) u_br_tgt (
        .pc_hi  (in_pc[VA_W-1:BR_LOW_W]),
        .lower  (rec_br_lower),
        .stat   (rec_br_stat),
        .target (br_tgt)
    );

    bpx_rebuild #(.VA_W(VA_W), .LOW_W(JMP_LOW_W)) u_tail_wide (
        .pc_hi  (in_pc[VA_W-1:JMP_LOW_W]),
        .lower  (rec_tail_lower),
        .stat   (rec_tail_stat),
        .target (tail_wide_tgt)
    );

    bpx_rebuild #(.VA_W(VA_W), .LOW_W(BR_LOW_W)) u_tail_narrow (
        .pc_hi  (in_pc[VA_W-1:BR_LOW_W]),
        .lower  (rec_tail_lower[BR_LOW_W-1:0]),
        .stat   (rec_tail_stat),
        .target (tail_narrow_tgt)
    );

    // A shared tail holds a conditional branch and so uses the short low field.
    always_comb tail_tgt = rec_tail_shared ? tail_narrow_tgt : tail_wide_tgt;

    bpx_fall_gen #(.VA_W(VA_W), .PRED_W(PRED_W), .ALN_W(ALN_W)) u_fall (
        .hit       (in_hit),
        .pc        (in_pc),
        .part      (rec_fall_part),
        .carry     (rec_fall_carry),
        .fall_addr (fall_addr),
        .fall_err  (fall_err)
    );

    bpx_flag_gen u_flags (
        .hit          (in_hit),
        .br_valid     (rec_br_valid),
        .tail_valid   (rec_tail_valid),
        .tail_shared  (rec_tail_shared),
        .is_call      (rec_is_call),
        .is_ret       (rec_is_ret),
        .is_jalr      (rec_is_jalr),
        .always_taken (rec_always_taken),
        .slot_valid   (slot_valid),
        .taken        (taken),
        .jal_o        (f_jal),
        .jalr_o       (f_jalr),
        .call_o       (f_call),
        .ret_o        (f_ret),
        .shared_o     (f_shared)
    );

    // Output stage: capture the expanded result on a valid input and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_slot_valid  <= '0;
            out_br_target   <= '0;
            out_tail_target <= '0;
            out_br_offset   <= '0;
            out_tail_offset <= '0;
            out_fall_addr   <= '0;
            out_fall_err    <= 1'b0;
            out_is_jal      <= 1'b0;
            out_is_jalr     <= 1'b0;
            out_is_call     <= 1'b0;
            out_is_ret      <= 1'b0;
            out_shared      <= 1'b0;
            out_taken       <= '0;
            out_jalr_target <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_slot_valid  <= slot_valid;
                out_br_target   <= br_tgt;
                out_tail_target <= tail_tgt;
                out_br_offset   <= rec_br_offset;
                out_tail_offset <= rec_tail_offset;
                out_fall_addr   <= fall_addr;
                out_fall_err    <= fall_err;
                out_is_jal      <= f_jal;
                out_is_jalr     <= f_jalr;
                out_is_call     <= f_call;
                out_is_ret      <= f_ret;
                out_shared      <= f_shared;
                out_taken       <= taken;
                out_jalr_target <= tail_tgt;
            end
        end
    end
endmodule

// File: rtl/bpx_expander_chk.sv
// Property checker for bpx_expander, attached by bind.
// Assumes in_valid is low while reset is asserted.
module bpx_expander_chk #(
    parameter int VA_W = 39
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_hit,
    input logic [VA_W-1:0] in_pc,
    input logic            out_valid,
    input logic [1:0]      out_slot_valid,
    input logic [VA_W-1:0] out_tail_target,
    input logic [VA_W-1:0] out_fall_addr,
    input logic            out_fall_err,
    input logic            out_is_jal,
    input logic            out_is_jalr,
    input logic            out_is_call,
    input logic            out_is_ret,
    input logic            out_shared,
    input logic [1:0]      out_taken,
    input logic [VA_W-1:0] out_jalr_target
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_fall_addr) && $stable(out_slot_valid) && $stable(out_taken)));

    a_r8_miss_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hit) |=> (out_slot_valid == 2'b00 && out_taken == 2'b00 &&
            !out_is_jal && !out_is_jalr && !out_is_call && !out_is_ret && !out_shared && !out_fall_err));

    a_r8_miss_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hit) |=> (out_fall_addr == $past(in_pc) + VA_W'(32)));

    a_r5_shared_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        out_shared |-> !(out_is_jal || out_is_jalr || out_is_call || out_is_ret));

    a_r5_jal_jalr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_is_jal, out_is_jalr}));

    a_r6_taken_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_taken & ~out_slot_valid) == 2'b00);

    a_r2_jalr_is_tail: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_jalr_target == out_tail_target));
endmodule

bind bpx_expander bpx_expander_chk #(.VA_W(VA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_hit          (in_hit),
    .in_pc           (in_pc),
    .out_valid       (out_valid),
    .out_slot_valid  (out_slot_valid),
    .out_tail_target (out_tail_target),
    .out_fall_addr   (out_fall_addr),
    .out_fall_err    (out_fall_err),
    .out_is_jal      (out_is_jal),
    .out_is_jalr     (out_is_jalr),
    .out_is_call     (out_is_call),
    .out_is_ret      (out_is_ret),
    .out_shared      (out_shared),
    .out_taken       (out_taken),
    .out_jalr_target (out_jalr_target)
);

// File: tb/test_bpx_expander.sv
// Self-checking bench: directed corners plus seeded random records.
module test_bpx_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_hit = 1'b0;
    logic [38:0] in_pc = '0;
    logic        br_v = 1'b0, tl_v = 1'b0, tl_sh = 1'b0, carry = 1'b0;
    logic [3:0]  br_off = '0, tl_off = '0, part = '0;
    logic [11:0] br_low = '0;
    logic [19:0] tl_low = '0;
    logic [1:0]  br_st = '0, tl_st = '0, at = '0;
    logic        is_call = 1'b0, is_ret = 1'b0, is_jalr = 1'b0;

    logic        o_valid, o_err, o_jal, o_jalr, o_call, o_ret, o_sh;
    logic [1:0]  o_sv, o_tk;
    logic [38:0] o_brt, o_tlt, o_fall, o_jt;
    logic [3:0]  o_broff, o_tloff;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bpx_expander i_bpx_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hit(in_hit), .in_pc(in_pc),
        .rec_br_valid(br_v), .rec_br_offset(br_off), .rec_br_lower(br_low), .rec_br_stat(br_st),
        .rec_tail_valid(tl_v), .rec_tail_offset(tl_off), .rec_tail_lower(tl_low),
        .rec_tail_stat(tl_st), .rec_tail_shared(tl_sh), .rec_fall_part(part),
        .rec_fall_carry(carry), .rec_is_call(is_call), .rec_is_ret(is_ret),
        .rec_is_jalr(is_jalr), .rec_always_taken(at),
        .out_valid(o_valid), .out_slot_valid(o_sv), .out_br_target(o_brt),
        .out_tail_target(o_tlt), .out_br_offset(o_broff), .out_tail_offset(o_tloff),
        .out_fall_addr(o_fall), .out_fall_err(o_err), .out_is_jal(o_jal),
        .out_is_jalr(o_jalr), .out_is_call(o_call), .out_is_ret(o_ret),
        .out_shared(o_sh), .out_taken(o_tk), .out_jalr_target(o_jt)
    );

    // Record one comparison and report a mismatch.
    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Target rebuilt from upper pc bits, a step code and lw stored low bits.
    function automatic logic [38:0] f_tgt(input logic [38:0] pc, input logic [19:0] low,
                                          input logic [1:0] st, input int lw);
        logic [63:0] up = 64'(pc) >> lw;
        if (st == 2'd1) up = up + 1;
        else if (st == 2'd2) up = up - 1;
        return 39'((up << lw) | (64'(low) & ((64'd1 << lw) - 1)));
    endfunction

    function automatic logic [38:0] f_raw_fall(input logic [38:0] pc, input logic c, input logic [3:0] p);
        logic [63:0] blk = (64'(pc) >> 5) + 64'(c);
        return 39'((blk << 5) | (64'(p) << 1));
    endfunction

    // Apply one record, then compare every output one cycle later.
    task automatic apply;
        logic [38:0] lim, raw, efall, etl;
        logic        eerr, tj;
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lim  = in_pc + 39'd32;
        raw  = f_raw_fall(in_pc, carry, part);
        eerr = in_hit && ((raw <= in_pc) || (raw > lim));
        efall = (in_hit && !eerr) ? raw : lim;
        etl  = tl_sh ? f_tgt(in_pc, tl_low, tl_st, 12) : f_tgt(in_pc, tl_low, tl_st, 20);
        tj   = in_hit && tl_v && !tl_sh;
        chk("R9", "out_valid", 64'(o_valid), 64'd1);
        chk("R1", "br_target", 64'(o_brt), 64'(f_tgt(in_pc, 20'(br_low), br_st, 12)));
        chk("R2", "tail_target", 64'(o_tlt), 64'(etl));
        chk("R2", "jalr_target", 64'(o_jt), 64'(etl));
        chk("R7", "slot_valid", 64'(o_sv), 64'({in_hit & tl_v, in_hit & br_v}));
        chk("R7", "offsets", 64'({o_tloff, o_broff}), 64'({tl_off, br_off}));
        chk(in_hit ? "R3" : "R8", "fall_addr", 64'(o_fall), 64'(efall));
        chk("R4", "fall_err", 64'(o_err), 64'(eerr));
        chk("R5", "flags", 64'({o_jal, o_jalr, o_call, o_ret, o_sh}),
            64'({tj & !is_jalr, tj & is_jalr, tj & is_call, tj & is_ret, in_hit & tl_v & tl_sh}));
        chk("R6", "taken", 64'(o_tk),
            64'({in_hit & tl_v & tl_sh & at[1], in_hit & br_v & at[0]}));
    endtask

    task automatic randomize_rec;
        in_pc   = 39'({$urandom, $urandom});
        in_hit  = ($urandom % 5) != 0;
        br_v    = 1'($urandom); tl_v = 1'($urandom); tl_sh = 1'($urandom);
        carry   = 1'($urandom); part = 4'($urandom);
        br_off  = 4'($urandom); tl_off = 4'($urandom);
        br_low  = 12'($urandom); tl_low = 20'($urandom);
        br_st   = 2'($urandom); tl_st = 2'($urandom); at = 2'($urandom);
        is_call = 1'($urandom); is_ret = 1'($urandom); is_jalr = 1'($urandom);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [38:0] hold_fall;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset out_valid", 64'(o_valid), 64'd0);
        chk("R10", "reset fall_addr", 64'(o_fall), 64'd0);
        chk("R10", "reset flags", 64'({o_sv, o_tk, o_jal, o_err}), 64'd0);
        rst_n = 1'b1;

        // R1 status 3 read as unchanged; R2 shared tail uses 12 low bits
        in_hit = 1'b1; in_pc = 39'h12_3456_7890; br_v = 1'b1; br_st = 2'd3;
        br_low = 12'hABC; tl_v = 1'b1; tl_sh = 1'b1; tl_st = 2'd1; tl_low = 20'hFFFFF;
        at = 2'b11; part = 4'd9; carry = 1'b0;
        apply();
        // R1 decrement wraps from zero upper bits; R5 jalr call in tail
        in_pc = 39'h000_0000_0100; br_st = 2'd2; tl_sh = 1'b0; tl_st = 2'd2;
        is_jalr = 1'b1; is_call = 1'b1; part = 4'd0; carry = 1'b1;
        apply();
        // R4 raw equals pc+32 exactly: no error
        in_pc = 39'h40_0000_0020; part = 4'd0; carry = 1'b1;
        apply();
        // R4 raw equals pc: error
        carry = 1'b0;
        apply();
        // R4 raw beyond pc+32: error
        in_pc = 39'h40_0000_0022; part = 4'd2; carry = 1'b1;
        apply();
        // R8 miss
        in_hit = 1'b0;
        apply();

        // R9 hold: inputs change without valid, outputs stay
        hold_fall = o_fall;
        @(negedge clk);
        in_pc = ~in_pc; in_hit = 1'b1;
        @(negedge clk);
        chk("R9", "out_valid low", 64'(o_valid), 64'd0);
        chk("R9", "fall held", 64'(o_fall), 64'(hold_fall));

        for (int i = 0; i < 400; i++) begin
            randomize_rec();
            apply();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule